// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the registers that host software uses to control one bus-master DMA channel. It stores a command byte, a status byte and a 32-bit base pointer to the descriptor table. The host reaches them through a simple I/O port that carries a register select, a byte offset and an access width. A change of the command's start bit becomes a start or stop request for the DMA engine. A start request also copies the base pointer into the engine's working table pointer.

The status byte has three fields. The active bit is driven by the start bit and by the engine's completion input. The error bit is set by the engine's error input. The interrupt bit latches a rising edge of the device interrupt, and the interrupt level itself passes straight through to the host line. Software clears the error and interrupt bits by writing ones to them. The DMA datapath and descriptor walking sit outside this block.

Reads are combinational from the select, offset and width inputs. Writes take effect on the clock edge where `io_wr` is high. Register select codes: 0 = command, 1 = status, 2 = base pointer, 3 = unmapped (reads zero, writes ignored). Width codes: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Command and status writes use `io_wdata[7:0]` whatever the offset.

Top module: `dma_chan_regs`

## Requirements
- R1: A command write keeps only bit 0 (start) and bit 3 (direction); a command read returns those two bits in place with every other bit zero, and `dir_o` follows bit 3.
- R2: A command write whose start bit equals the stored start bit raises neither `start_req` nor `stop_req`.
- R3: A 0-to-1 change of the start bit does three things in the cycle after the write: it loads `cur_ptr` from the base register, sets status bit 0 (active), and drives `start_req` high for exactly one cycle.
- R4: A 1-to-0 change of the start bit clears status bit 0 and drives `stop_req` high for exactly one cycle after the write.
- R5: A base write replaces only the bytes from `io_off` upward, over the access width, and leaves the other bytes unchanged. Bits 1:0 of the stored base are always zero.
- R6: A base read returns the stored base shifted right by 8 times `io_off`, masked to the access width.
- R7: A rising edge on `dev_irq` sets status bit 2 (interrupt); `irq_o` equals `dev_irq` at all times.
- R8: Status reads show bit 0 active, bit 1 error and bit 2 interrupt, with other bits zero. Writing 1 to bit 1 or bit 2 clears that bit. Writes to bit 0 have no effect. A hardware set in the same cycle wins over the clear.
- R9: `eng_done` clears the active bit unless a start rise occurs in the same cycle; `eng_err` sets the error bit.
- R10: Reset clears the command, status, base and `cur_ptr`, and the request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Write strobe for the selected register |
| io_sel | input | 2 | Register select (0 cmd, 1 status, 2 base, 3 none) |
| io_off | input | 2 | Byte offset within the register |
| io_size | input | 2 | Access width code (0 = 1 B, 1 = 2 B, else 4 B) |
| io_wdata | input | 32 | Write data, least significant byte first |
| io_rdata | output | 32 | Read data for the current select, offset and width |
| eng_done | input | 1 | Engine completion, clears active |
| eng_err | input | 1 | Engine error, sets error bit |
| dev_irq | input | 1 | Device interrupt level |
| irq_o | output | 1 | Interrupt line to host (level pass-through) |
| start_req | output | 1 | One-cycle start request to the engine |
| stop_req | output | 1 | One-cycle stop request to the engine |
| dir_o | output | 1 | Direction bit from the command register |
| cur_ptr | output | 32 | Descriptor table pointer loaded on start |

## Verification
Directed cases come first. Base writes at full width and at a single byte show whether the byte merge and the low-bit forcing are both right. A two-byte read at offset 1 separates the shift from the width mask. Command writes of all ones, a repeat with the same start bit, and a clearing write tell apart the rising, unchanged and falling start cases and the write mask. A random mix of register writes, offsets, widths, engine pulses and interrupt toggles then checks every cycle against a bench model. This exposes collisions such as a start rise meeting `eng_done`, or a write-one-to-clear meeting a hardware set.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_BASE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 3;
  localparam int ST_ACT_BIT    = 0;
  localparam int ST_ERR_BIT    = 1;
  localparam int ST_INT_BIT    = 2;

  function automatic int size_to_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/dma_cmd_unit.sv
module dma_cmd_unit
  import dma_regs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] base_in,
  output logic [7:0]    cmd_o,
  output logic          rise_o,
  output logic          fall_o,
  output logic          start_req_o,
  output logic          stop_req_o,
  output logic [AW-1:0] cur_ptr_o
);

  logic          start_q, start_n;
  logic          dir_q, dir_n;
  logic          sreq_q, sreq_n;
  logic          preq_q, preq_n;
  logic [AW-1:0] ptr_q, ptr_n;
  logic          new_start;

  assign new_start = wdata[CMD_START_BIT];
  assign rise_o    = wr_en && new_start && !start_q;
  assign fall_o    = wr_en && !new_start && start_q;

  always_comb begin
    start_n = start_q;
    dir_n   = dir_q;
    ptr_n   = ptr_q;
    sreq_n  = rise_o;
    preq_n  = fall_o;
    if (wr_en) begin
      start_n = new_start;
      dir_n   = wdata[CMD_DIR_BIT];
    end
    if (rise_o) begin
      ptr_n = base_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      sreq_q  <= 1'b0;
      preq_q  <= 1'b0;
      ptr_q   <= '0;
    end else begin
      sreq_q <= sreq_n;
      preq_q <= preq_n;
      if (wr_en) begin
        start_q <= start_n;
        dir_q   <= dir_n;
      end
      if (rise_o) begin
        ptr_q <= ptr_n;
      end
    end
  end

  always_comb begin
    cmd_o = 8'h00;
    cmd_o[CMD_START_BIT] = start_q;
    cmd_o[CMD_DIR_BIT]   = dir_q;
  end

  assign start_req_o = sreq_q;
  assign stop_req_o  = preq_q;
  assign cur_ptr_o   = ptr_q;

  // R2: an unchanged start bit produces no request
  assert_same_start_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wdata[CMD_START_BIT] == cmd_o[CMD_START_BIT])) |=> (!start_req_o && !stop_req_o));

  // R3: rising start pulses a request and loads the pointer from base
  assert_rise_loads_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[CMD_START_BIT] && !cmd_o[CMD_START_BIT]) |=> (start_req_o && (cur_ptr_o == $past(base_in))));

  // R3: start request lasts one cycle
  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_req_o |=> !start_req_o);

  // R4: falling start pulses a stop request
  assert_fall_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[CMD_START_BIT] && cmd_o[CMD_START_BIT]) |=> stop_req_o);

endmodule

// File: rtl/dma_stat_unit.sv
module dma_stat_unit
  import dma_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       done_i,
  input  logic       err_i,
  input  logic       dev_irq_i,
  output logic [7:0] stat_o
);

  logic act_q, act_n;
  logic err_q, err_n;
  logic int_q, int_n;
  logic irq_q;
  logic irq_rise;
  logic clr_err, clr_int;

  assign irq_rise = dev_irq_i && !irq_q;
  assign clr_err  = wr_en && wdata[ST_ERR_BIT];
  assign clr_int  = wr_en && wdata[ST_INT_BIT];

  always_comb begin
    act_n = act_q;
    if (rise_i) begin
      act_n = 1'b1;
    end else if (fall_i || done_i) begin
      act_n = 1'b0;
    end
    err_n = (err_q && !clr_err) || err_i;
    int_n = (int_q && !clr_int) || irq_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
      int_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      act_q <= act_n;
      err_q <= err_n;
      int_q <= int_n;
      irq_q <= dev_irq_i;
    end
  end

  always_comb begin
    stat_o = 8'h00;
    stat_o[ST_ACT_BIT] = act_q;
    stat_o[ST_ERR_BIT] = err_q;
    stat_o[ST_INT_BIT] = int_q;
  end

  // R3: start rise sets active
  assert_rise_sets_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> stat_o[ST_ACT_BIT]);

  // R4: stop clears active
  assert_fall_clears_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && !rise_i) |=> !stat_o[ST_ACT_BIT]);

  // R7: device interrupt edge is latched
  assert_irq_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_irq_i && !irq_q) |=> stat_o[ST_INT_BIT]);

  // R8: write-one clears error when no new error arrives
  assert_err_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[ST_ERR_BIT] && !err_i) |=> !stat_o[ST_ERR_BIT]);

  // R9: engine error sets the error bit
  assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_i |=> stat_o[ST_ERR_BIT]);

endmodule

// File: rtl/dma_base_unit.sv
module dma_base_unit
  import dma_regs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    off_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] rdata_o
);

  localparam int NB = AW / 8;

  logic [AW-1:0] base_q, base_n;
  logic [AW-1:0] merged;
  logic [AW-1:0] wshift, rshift;
  logic [NB-1:0] hit;
  int            nbytes;

  assign nbytes = size_to_bytes(size_i);
  assign wshift = wdata << {off_i, 3'b000};
  assign rshift = base_q >> {off_i, 3'b000};

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign hit[b] = (b >= int'(off_i)) && (b < int'(off_i) + nbytes);
    assign merged[b*8 +: 8] = hit[b] ? wshift[b*8 +: 8] : base_q[b*8 +: 8];
    assign rdata_o[b*8 +: 8] = (b < nbytes) ? rshift[b*8 +: 8] : 8'h00;
  end

  assign base_n = {merged[AW-1:2], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (wr_en) begin
      base_q <= base_n;
    end
  end

  assign base_o = base_q;

  // R5: base holds its value without a write
  assert_base_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base_o));

  // R5: bytes outside the access keep their old contents
  assert_base_low_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (off_i != 2'd0)) |=> (base_o[7:0] == $past(base_o[7:0])));

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_wr,
  input  logic [1:0]    io_sel,
  input  logic [1:0]    io_off,
  input  logic [1:0]    io_size,
  input  logic [AW-1:0] io_wdata,
  output logic [AW-1:0] io_rdata,
  input  logic          eng_done,
  input  logic          eng_err,
  input  logic          dev_irq,
  output logic          irq_o,
  output logic          start_req,
  output logic          stop_req,
  output logic          dir_o,
  output logic [AW-1:0] cur_ptr
);

  logic          rst_s1, rst_s2;
  logic          cmd_wr, stat_wr, base_wr;
  logic [7:0]    cmd_byte, stat_byte;
  logic [AW-1:0] base_val, base_rd;
  logic          rise, fall;
  reg_sel_e      sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  assign sel     = reg_sel_e'(io_sel);
  assign cmd_wr  = io_wr && (sel == SEL_CMD);
  assign stat_wr = io_wr && (sel == SEL_STAT);
  assign base_wr = io_wr && (sel == SEL_BASE);

  dma_cmd_unit #(.AW(AW)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_s2),
    .wr_en      (cmd_wr),
    .wdata      (io_wdata[7:0]),
    .base_in    (base_val),
    .cmd_o      (cmd_byte),
    .rise_o     (rise),
    .fall_o     (fall),
    .start_req_o(start_req),
    .stop_req_o (stop_req),
    .cur_ptr_o  (cur_ptr)
  );

  dma_stat_unit u_stat (
    .clk      (clk),
    .rst_n    (rst_s2),
    .wr_en    (stat_wr),
    .wdata    (io_wdata[7:0]),
    .rise_i   (rise),
    .fall_i   (fall),
    .done_i   (eng_done),
    .err_i    (eng_err),
    .dev_irq_i(dev_irq),
    .stat_o   (stat_byte)
  );

  dma_base_unit #(.AW(AW)) u_base (
    .clk    (clk),
    .rst_n  (rst_s2),
    .wr_en  (base_wr),
    .off_i  (io_off),
    .size_i (io_size),
    .wdata  (io_wdata),
    .base_o (base_val),
    .rdata_o(base_rd)
  );

  always_comb begin
    case (sel)
      SEL_CMD:  io_rdata = {{(AW-8){1'b0}}, cmd_byte};
      SEL_STAT: io_rdata = {{(AW-8){1'b0}}, stat_byte};
      SEL_BASE: io_rdata = base_rd;
      default:  io_rdata = '0;
    endcase
  end

  assign irq_o = dev_irq;
  assign dir_o = cmd_byte[CMD_DIR_BIT];

  // R9: completion clears active when no start rise coincides
  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_s2)
    (eng_done && !(io_wr && (io_sel == 2'd0) && io_wdata[0] && !dir_or_start_q())) |=> !stat_byte[ST_ACT_BIT]);

  // R10: requests are low while held in reset
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_s2 |-> (!start_req && !stop_req && (cur_ptr == '0)));

  function automatic logic dir_or_start_q();
    return cmd_byte[CMD_START_BIT];
  endfunction

endmodule

// File: tb/dma_chan_regs_test.sv
`timescale 1ns/1ps
module dma_chan_regs_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_wr;
  logic [1:0]  io_sel, io_off, io_size;
  logic [31:0] io_wdata, io_rdata;
  logic        eng_done, eng_err, dev_irq;
  logic        irq_o, start_req, stop_req, dir_o;
  logic [31:0] cur_ptr;

  int tests = 0;
  int fails = 0;

  logic [7:0]  m_cmd;
  logic        m_act, m_err, m_int, m_irq_prev;
  logic [31:0] m_base, m_ptr;
  logic        e_start, e_stop;

  always #2.5 clk = ~clk;

  dma_chan_regs uut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_sel(io_sel), .io_off(io_off),
    .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .eng_done(eng_done), .eng_err(eng_err), .dev_irq(dev_irq), .irq_o(irq_o),
    .start_req(start_req), .stop_req(stop_req), .dir_o(dir_o), .cur_ptr(cur_ptr)
  );

  function automatic logic [63:0] width_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 64'hFF;
      2'd1:    return 64'hFFFF;
      default: return 64'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] base_after(input logic [31:0] b, input logic [1:0] off,
                                             input logic [1:0] sz, input logic [31:0] d);
    logic [63:0] m, r;
    m = width_mask(sz) << (off * 8);
    r = ({32'h0, b} & ~m) | (({32'h0, d} << (off * 8)) & m);
    return r[31:0] & 32'hFFFF_FFFC;
  endfunction

  function automatic logic [31:0] base_view(input logic [31:0] b, input logic [1:0] off,
                                            input logic [1:0] sz);
    logic [63:0] r;
    r = ({32'h0, b} >> (off * 8)) & width_mask(sz);
    return r[31:0];
  endfunction

  function automatic logic [31:0] expect_read(input logic [1:0] sel, input logic [1:0] off,
                                              input logic [1:0] sz);
    case (sel)
      2'd0:    return {24'h0, m_cmd};
      2'd1:    return {29'h0, m_int, m_err, m_act};
      2'd2:    return base_view(m_base, off, sz);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cmd = 8'h00; m_act = 1'b0; m_err = 1'b0; m_int = 1'b0;
    m_base = 32'h0; m_ptr = 32'h0; m_irq_prev = 1'b0;
  endtask

  // one clock cycle of stimulus, then check the registered outputs
  task automatic cycle(input logic wr, input logic [1:0] sel, input logic [1:0] off,
                       input logic [1:0] sz, input logic [31:0] wd,
                       input logic dn, input logic er, input logic iq);
    logic rise, fall, irise;
    io_wr = wr; io_sel = sel; io_off = off; io_size = sz; io_wdata = wd;
    eng_done = dn; eng_err = er; dev_irq = iq;
    #0.1;
    chk("R7 irq_o", {31'h0, irq_o}, {31'h0, iq});
    rise = wr && sel == 2'd0 && wd[0] && !m_cmd[0];
    fall = wr && sel == 2'd0 && !wd[0] && m_cmd[0];
    irise = iq && !m_irq_prev;
    m_irq_prev = iq;
    if (rise) m_ptr = m_base;
    if (rise) m_act = 1'b1;
    else if (fall || dn) m_act = 1'b0;
    m_err = (m_err && !(wr && sel == 2'd1 && wd[1])) || er;
    m_int = (m_int && !(wr && sel == 2'd1 && wd[2])) || irise;
    if (wr && sel == 2'd0) m_cmd = wd[7:0] & 8'h09;
    if (wr && sel == 2'd2) m_base = base_after(m_base, off, sz, wd);
    e_start = rise; e_stop = fall;
    @(negedge clk);
    chk("R3 start_req", {31'h0, start_req}, {31'h0, e_start});
    chk("R4 stop_req", {31'h0, stop_req}, {31'h0, e_stop});
    chk("R3 cur_ptr", cur_ptr, m_ptr);
    chk("R1 dir_o", {31'h0, dir_o}, {31'h0, m_cmd[3]});
  endtask

  task automatic rd_check(input logic [1:0] sel, input logic [1:0] off, input logic [1:0] sz);
    string tag;
    io_wr = 1'b0; io_sel = sel; io_off = off; io_size = sz;
    eng_done = 1'b0; eng_err = 1'b0;
    #0.1;
    case (sel)
      2'd0: tag = "R1 cmd read";
      2'd1: tag = "R8 status read";
      2'd2: tag = "R6 base read";
      default: tag = "R6 unmapped read";
    endcase
    chk(tag, io_rdata, expect_read(sel, off, sz));
  endtask

  task automatic read_all();
    rd_check(2'd0, 2'd0, 2'd0);
    rd_check(2'd1, 2'd0, 2'd0);
    rd_check(2'd2, 2'd0, 2'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; io_wr = 1'b0; io_sel = 2'd0; io_off = 2'd0; io_size = 2'd0;
    io_wdata = 32'h0; eng_done = 1'b0; eng_err = 1'b0; dev_irq = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 start_req", {31'h0, start_req}, 32'h0);
    chk("R10 cur_ptr", cur_ptr, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_check(2'd0, 2'd0, 2'd0); chk("R10 cmd", io_rdata, 32'h0);
    rd_check(2'd1, 2'd0, 2'd0); chk("R10 status", io_rdata, 32'h0);
    rd_check(2'd2, 2'd0, 2'd2); chk("R10 base", io_rdata, 32'h0);

    // R5: full write forces low bits to zero
    cycle(1'b1, 2'd2, 2'd0, 2'd2, 32'h1234_5677, 1'b0, 1'b0, 1'b0);
    rd_check(2'd2, 2'd0, 2'd2); chk("R5 base align", io_rdata, 32'h1234_5674);
    // R5: single byte at offset 2
    cycle(1'b1, 2'd2, 2'd2, 2'd0, 32'h0000_00AB, 1'b0, 1'b0, 1'b0);
    rd_check(2'd2, 2'd0, 2'd2); chk("R5 byte merge", io_rdata, 32'h12AB_5674);
    // R6: two-byte read at offset 1
    rd_check(2'd2, 2'd1, 2'd1); chk("R6 shift mask", io_rdata, 32'h0000_AB56);

    // R1 and R3: all-ones command write
    cycle(1'b1, 2'd0, 2'd0, 2'd0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    chk("R3 ptr loaded", cur_ptr, 32'h12AB_5674);
    rd_check(2'd0, 2'd0, 2'd0); chk("R1 cmd mask", io_rdata, 32'h0000_0009);
    rd_check(2'd1, 2'd0, 2'd0); chk("R3 active set", io_rdata, 32'h1);
    cycle(1'b0, 2'd0, 2'd0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0);
    // R2: same start bit again
    cycle(1'b1, 2'd0, 2'd0, 2'd0, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
    chk("R2 no start", {31'h0, start_req}, 32'h0);
    // R8: writing status bit 0 does nothing
    cycle(1'b1, 2'd1, 2'd0, 2'd0, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
    rd_check(2'd1, 2'd0, 2'd0); chk("R8 bit0 ignored", io_rdata, 32'h1);
    // R4: stop
    cycle(1'b1, 2'd0, 2'd0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0);
    chk("R4 stop pulse", {31'h0, stop_req}, 32'h1);
    rd_check(2'd1, 2'd0, 2'd0); chk("R4 active clear", io_rdata, 32'h0);
    // R7: interrupt edge and level
    cycle(1'b0, 2'd0, 2'd0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b1);
    rd_check(2'd1, 2'd0, 2'd0); chk("R7 int latched", io_rdata, 32'h4);
    // R9: error input, R8: clear both, set wins on collision
    cycle(1'b0, 2'd0, 2'd0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0);
    rd_check(2'd1, 2'd0, 2'd0); chk("R9 err set", io_rdata, 32'h6);
    cycle(1'b1, 2'd1, 2'd0, 2'd0, 32'h0000_0006, 1'b0, 1'b1, 1'b0);
    rd_check(2'd1, 2'd0, 2'd0); chk("R8 set wins", io_rdata, 32'h2);
    cycle(1'b1, 2'd1, 2'd0, 2'd0, 32'h0000_0002, 1'b0, 1'b0, 1'b0);
    rd_check(2'd1, 2'd0, 2'd0); chk("R8 w1c", io_rdata, 32'h0);
    // R9: done clears active; start beats done
    cycle(1'b1, 2'd0, 2'd0, 2'd0, 32'h1, 1'b1, 1'b0, 1'b0);
    rd_check(2'd1, 2'd0, 2'd0); chk("R9 start beats done", io_rdata, 32'h1);
    cycle(1'b0, 2'd0, 2'd0, 2'd0, 32'h0, 1'b1, 1'b0, 1'b0);
    rd_check(2'd1, 2'd0, 2'd0); chk("R9 done clears", io_rdata, 32'h0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [1:0] s;
      logic iq;
      s = 2'($urandom % 4);
      iq = ($urandom % 4 == 0) ? !m_irq_prev : m_irq_prev;
      cycle(($urandom % 4) != 0, s, 2'($urandom % 4), 2'($urandom % 4), $urandom,
            ($urandom % 8) == 0, ($urandom % 16) == 0, iq);
      rd_check(2'($urandom % 4), 2'($urandom % 4), 2'($urandom % 4));
      if (i % 50 == 0) read_all();
    end

    // R10: reset in mid-run
    rst_n = 1'b0;
    model_reset();
    dev_irq = 1'b0;
    #1;
    read_all();
    chk("R10 cur_ptr", cur_ptr, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_all();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule